// File: doc/BRIEF.md
# Accumulator Processor Core with Explicit Micro-Step Sequencing

This block is a compact accumulator machine that runs each instruction as a chain of single register moves. Its registers are a program counter, an instruction register, an accumulator, and a pair of registers that stand between the core and memory: one holds the memory address and one holds the memory data word. Every clock step copies exactly one value from one register into another. The current step number goes out on a port, so the order of the steps can be checked from outside.

The core connects to one single-port memory. The memory address port always shows the address register. The write-data port always shows the data register. The memory returns the addressed word on the read-data input in the same cycle, and it writes on the clock edge while the write strobe is high. An instruction word carries a 4-bit opcode in bits [11:8] and an 8-bit operand address in bits [7:0]. There are opcodes for load, add, subtract, store, three kinds of branch and halt.

After reset the core fetches from address 0. It runs until it decodes a halt, and then it holds `done` high until the next reset.

Top module: `acc_core`

## Requirements
- R1: While `rst_n` is low and after it is released, every register is zero, `state_o` is 0, and `done`, `mem_we`, `zero_o`, `neg_o`, `acc_o` and `mem_addr` are all 0.
- R2: Fetch takes three steps in this order: F_MAR=0 (address register takes the program counter), F_MDR=1 (data register takes read data), F_IR=2 (instruction register takes the data register). Each step lasts one cycle.
- R3: Store (opcode 3) runs the steps 3 (X_MAR, address register takes IR[7:0]), 6 (X_ST, data register takes the accumulator), 7 (X_WR) and 8 (PC_INC). `mem_we` is high only during step 7, with `mem_addr` set to the operand address and `mem_wdata` set to the accumulator.
- R4: Load (5), add (1) and subtract (2) run the steps 3, 4 (X_MDR, data register takes read data), 5 (X_ALU, accumulator is updated) and 8. Arithmetic is 12-bit two's complement and wraps.
- R5: In step 5, `zero_o` becomes 1 exactly when the new accumulator is zero, and `neg_o` takes the new accumulator's bit 11. No other step changes the flags.
- R6: Branch-always (6), branch-if-zero (7) and branch-if-positive (8) take one execute step, 9. A taken branch loads IR[7:0] into the program counter. A branch that is not taken adds one to the program counter. Branch-if-positive is taken only when both flags are 0.
- R7: Halt (opcode 0) moves to step 10. The core then stays there with `done` high and `mem_we` low until reset.
- R8: Opcodes 4 and 9 to 15 are no-operations. After fetch they go straight to step 8, and the accumulator is not changed.
- R9: Step 8 adds one to the program counter, so the next fetch reads the following address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 8 | Memory address (address register) |
| mem_wdata | output | 12 | Memory write data (data register) |
| mem_rdata | input | 12 | Word read from `mem_addr` |
| mem_we | output | 1 | Memory write strobe |
| state_o | output | 4 | Current micro-step code |
| done | output | 1 | High while halted |
| acc_o | output | 12 | Accumulator |
| zero_o | output | 1 | Zero flag |
| neg_o | output | 1 | Negative flag |

## Verification
Each step code appears one cycle after the step before it. The bench therefore takes one sample of `state_o`, `mem_we` and `mem_addr` on every falling edge after reset is released, and compares the sample with the expected step at that index. Fetch takes three cycles. Load, add, subtract and store take four more, a branch takes one more, and a no-operation takes one more. The bench adds these counts to predict the exact cycle in which `done` first rises. The accumulator results, the flags and the stored words appear only once the program halts, so the bench checks them after `done` is seen.

// File: rtl/acc_core.sv
module acc_core #(
  parameter int DW = 12,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  output logic [3:0]    state_o,
  output logic          done,
  output logic [DW-1:0] acc_o,
  output logic          zero_o,
  output logic          neg_o
);
  localparam int OPW = DW - AW;

  typedef enum logic [3:0] {
    F_MAR = 4'd0, F_MDR = 4'd1, F_IR = 4'd2, X_MAR = 4'd3, X_MDR = 4'd4,
    X_ALU = 4'd5, X_ST = 4'd6, X_WR = 4'd7, PC_INC = 4'd8, BR = 4'd9,
    HALT = 4'd10
  } step_t;

  step_t st;
  logic [AW-1:0] pc, mar;
  logic [DW-1:0] mdr, ir, acc;
  logic zf, nf;

  wire [OPW-1:0] op     = ir[DW-1 -: OPW];
  wire [OPW-1:0] new_op = mdr[DW-1 -: OPW];
  wire [AW-1:0]  field  = ir[AW-1:0];

  logic [DW-1:0] alu;
  always_comb begin
    case (op)
      4'd1:    alu = acc + mdr;
      4'd2:    alu = acc - mdr;
      default: alu = mdr;
    endcase
  end

  logic taken;
  always_comb begin
    case (op)
      4'd6:    taken = 1'b1;
      4'd7:    taken = zf;
      4'd8:    taken = !zf && !nf;
      default: taken = 1'b0;
    endcase
  end

  step_t dispatch;
  always_comb begin
    case (new_op)
      4'd0:                   dispatch = HALT;
      4'd1, 4'd2, 4'd3, 4'd5: dispatch = X_MAR;
      4'd6, 4'd7, 4'd8:       dispatch = BR;
      default:                dispatch = PC_INC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= F_MAR;
      pc  <= '0;
      mar <= '0;
      mdr <= '0;
      ir  <= '0;
      acc <= '0;
      zf  <= 1'b0;
      nf  <= 1'b0;
    end else begin
      case (st)
        F_MAR:  begin mar <= pc;        st <= F_MDR; end
        F_MDR:  begin mdr <= mem_rdata; st <= F_IR;  end
        F_IR:   begin ir  <= mdr;       st <= dispatch; end
        X_MAR:  begin
          mar <= field;
          st  <= (op == 4'd3) ? X_ST : X_MDR;
        end
        X_MDR:  begin mdr <= mem_rdata; st <= X_ALU; end
        X_ALU:  begin
          acc <= alu;
          zf  <= (alu == '0);
          nf  <= alu[DW-1];
          st  <= PC_INC;
        end
        X_ST:   begin mdr <= acc; st <= X_WR; end
        X_WR:   st <= PC_INC;
        PC_INC: begin pc <= pc + 1'b1; st <= F_MAR; end
        BR:     begin pc <= taken ? field : pc + 1'b1; st <= F_MAR; end
        HALT:   st <= HALT;
        default: st <= F_MAR;
      endcase
    end
  end

  assign mem_addr  = mar;
  assign mem_wdata = mdr;
  assign mem_we    = (st == X_WR);
  assign state_o   = st;
  assign done      = (st == HALT);
  assign acc_o     = acc;
  assign zero_o    = zf;
  assign neg_o     = nf;
endmodule

module acc_core_chk #(
  parameter int DW = 12,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_we,
  input logic [DW-1:0] mem_wdata,
  input logic [3:0]    state_o,
  input logic          done,
  input logic [DW-1:0] acc_o,
  input logic          zero_o,
  input logic          neg_o
);
  // R2
  fetch_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 4'd0 |=> state_o == 4'd1);
  // R2
  fetch_ir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 4'd1 |=> state_o == 4'd2);
  // R3
  write_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(state_o) == 4'd6 && mem_wdata == acc_o);
  // R4
  alu_then_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 4'd5 |=> state_o == 4'd8);
  // R5
  flag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(state_o) == 4'd5 |-> zero_o == (acc_o == '0) && neg_o == acc_o[DW-1]);
  // R7
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && !mem_we && $stable(acc_o));
endmodule

bind acc_core acc_core_chk #(.DW(DW), .AW(AW)) u_acc_core_chk (
  .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_wdata(mem_wdata),
  .state_o(state_o), .done(done), .acc_o(acc_o), .zero_o(zero_o), .neg_o(neg_o)
);

// File: tb/acc_core_bench.sv
module acc_core_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  mem_addr;
  logic [11:0] mem_wdata, mem_rdata, acc_o;
  logic mem_we, done, zero_o, neg_o;
  logic [3:0] state_o;
  logic [11:0] mem [256];
  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  acc_core u_acc_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .state_o(state_o), .done(done),
    .acc_o(acc_o), .zero_o(zero_o), .neg_o(neg_o)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  // {op, a, b, expected}
  localparam logic [39:0] VEC [6] = '{
    40'h1_005_007_00C, 40'h2_005_007_FFE, 40'h1_FFF_001_000,
    40'h2_800_001_7FF, 40'h1_7FF_001_800, 40'h2_003_003_000
  };
  localparam int ADD_TR [8] = '{0, 1, 2, 3, 4, 5, 8, 0};
  localparam int ST_TR  [8] = '{0, 1, 2, 3, 6, 7, 8, 0};

  function automatic logic [11:0] ins(input logic [3:0] op, input logic [7:0] a);
    return {op, a};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 12'h0;
  endtask

  task automatic release_rst();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_to_done(output int n);
    release_rst();
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    clear_mem();
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 state", state_o, 0);
    chk("R1 done", done, 0);
    chk("R1 acc", acc_o, 0);
    chk("R1 we", mem_we, 0);
    chk("R1 addr", mem_addr, 0);
    chk("R1 flags", {zero_o, neg_o}, 0);

    // R2 R4 add trace, R9 next fetch address
    clear_mem();
    mem[0] = ins(4'd1, 8'h10);
    mem[1] = ins(4'd0, 8'h00);
    mem[8'h10] = 12'h021;
    release_rst();
    for (int i = 0; i < 8; i++) begin
      chk($sformatf("R2/R4 add step %0d", i), state_o, ADD_TR[i]);
      if (i < 7) @(negedge clk);
    end
    @(negedge clk);
    chk("R9 next fetch address", mem_addr, 1);
    chk("R4 add result", acc_o, 12'h021);

    // R3 store trace and strobe
    clear_mem();
    mem[0] = ins(4'd3, 8'h30);
    mem[8'h30] = 12'h555;
    release_rst();
    for (int i = 0; i < 8; i++) begin
      chk($sformatf("R3 store step %0d", i), state_o, ST_TR[i]);
      chk($sformatf("R3 we step %0d", i), mem_we, (i == 5));
      if (i == 5) chk("R3 write addr/data", {mem_addr, mem_wdata}, {8'h30, 12'h000});
      if (i < 7) @(negedge clk);
    end
    chk("R3 stored word", mem[8'h30], 12'h000);

    // R4 R5 arithmetic table
    for (int v = 0; v < 6; v++) begin
      logic [11:0] e;
      clear_mem();
      e = VEC[v][11:0];
      mem[0] = ins(4'd5, 8'h80);
      mem[1] = ins(VEC[v][39:36], 8'h81);
      mem[2] = ins(4'd3, 8'h82);
      mem[3] = ins(4'd0, 8'h00);
      mem[8'h80] = VEC[v][35:24];
      mem[8'h81] = VEC[v][23:12];
      mem[8'h82] = 12'hABC;
      run_to_done(n);
      chk($sformatf("R4 vec %0d result", v), mem[8'h82], e);
      chk($sformatf("R5 vec %0d zero", v), zero_o, (e == 12'h0));
      chk($sformatf("R5 vec %0d neg", v), neg_o, e[11]);
    end

    // R6 branches
    for (int b = 0; b < 6; b++) begin
      logic [3:0] op;
      logic [11:0] v;
      logic tk;
      case (b)
        0: begin op = 4'd7; v = 12'h000; end
        1: begin op = 4'd7; v = 12'h005; end
        2: begin op = 4'd8; v = 12'h005; end
        3: begin op = 4'd8; v = 12'h000; end
        4: begin op = 4'd8; v = 12'h800; end
        default: begin op = 4'd6; v = 12'h800; end
      endcase
      tk = (op == 4'd6) || (op == 4'd7 && v == 0) || (op == 4'd8 && v != 0 && !v[11]);
      clear_mem();
      mem[0] = ins(4'd5, 8'h20);
      mem[1] = ins(op, 8'h05);
      mem[2] = ins(4'd5, 8'h21);
      mem[3] = ins(4'd3, 8'h30);
      mem[4] = ins(4'd0, 8'h00);
      mem[5] = ins(4'd5, 8'h22);
      mem[6] = ins(4'd3, 8'h30);
      mem[7] = ins(4'd0, 8'h00);
      mem[8'h20] = v;
      mem[8'h21] = 12'h111;
      mem[8'h22] = 12'h222;
      run_to_done(n);
      chk($sformatf("R6 branch case %0d", b), mem[8'h30], tk ? 12'h222 : 12'h111);
    end

    // R8 undefined opcode, exact cycle of done
    clear_mem();
    mem[0] = ins(4'd5, 8'h20);
    mem[1] = ins(4'd4, 8'h21);
    mem[2] = ins(4'd3, 8'h30);
    mem[3] = ins(4'd0, 8'h00);
    mem[8'h20] = 12'h123;
    mem[8'h21] = 12'h777;
    run_to_done(n);
    chk("R8 done cycle", n, 21);
    chk("R8 acc kept", mem[8'h30], 12'h123);

    // R7 halt holds
    clear_mem();
    mem[0] = ins(4'd0, 8'h00);
    run_to_done(n);
    chk("R7 halt cycle", n, 3);
    begin
      logic seen_we = 1'b0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (mem_we) seen_we = 1'b1;
      end
      chk("R7 still halted", {state_o, done}, {4'd10, 1'b1});
      chk("R7 no write", seen_we, 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule